// File: doc/BRIEF.md
# RTC Alarm Field Matcher

This block keeps one alarm register set laid out like the calendar time counter: seconds, minutes, hours, weekday, date, month and year, one byte per field. The top bit of each byte is a per-field enable. The lower bits hold the value that the field must equal. The block does not count time and does not carry a register bus. The time counter supplies the live field values and a one-cycle pulse for each second. Software-side logic writes alarm bytes one at a time, reads them back, disarms the alarm and clears the pending status.

On each second pulse, the block compares the enabled fields against the live time. Disabled fields are don't-care. When every enabled field matches and at least one field is enabled, the block emits a single-cycle interrupt pulse and sets a sticky pending flag. A disarm command drops the enable bit of every byte and keeps the stored values, so the alarm can be re-armed later without rewriting them.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, `irq_o`, `pending_o` and `armed_o` are 0, and every alarm byte reads back as 0.
- R2: A write pulse on `alm_wr_i` stores `alm_wr_data_i` into the byte selected by `alm_wr_idx_i` at that clock edge. `alm_rd_data_o` is a combinational view of the byte selected by `alm_rd_idx_i`. Field indices are: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year.
- R3: `armed_o` is 1 exactly when bit 7 of at least one stored alarm byte is 1.
- R4: Consider a cycle with `tick_i` high in which, for every byte whose bit 7 is set, bits 6:0 equal the time field `time_i[7k+6:7k]`. Then `irq_o` is high for one cycle in the following cycle. A byte whose bit 7 is clear takes no part in the comparison.
- R5: If no enable bit is set, a tick never raises `irq_o`, whatever the stored values and the time are.
- R6: Without `tick_i`, `irq_o` stays low even when the time matches the alarm.
- R7: A mismatch in any single enabled field suppresses the interrupt on that tick.
- R8: `pending_o` goes high in the same cycle as `irq_o` and holds until a cycle with `pend_clr_i` high. If a clear and a new match fall in the same cycle, the flag stays set.
- R9: `alm_disarm_i` clears bit 7 of every alarm byte and leaves bits 6:0 unchanged. A byte written in the same cycle takes the written value in full.
- R10: A write to index 7, which has no field, changes no byte. Reading index 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle pulse per second from the time counter |
| time_i | input | 49 | Live time, seven 7-bit fields, seconds in the low bits |
| alm_wr_i | input | 1 | Alarm byte write strobe |
| alm_wr_idx_i | input | 3 | Field index of the write |
| alm_wr_data_i | input | 8 | Byte to write: bit 7 enable, bits 6:0 value |
| alm_disarm_i | input | 1 | Clear every enable bit, keep values |
| alm_rd_idx_i | input | 3 | Field index for readback |
| alm_rd_data_o | output | 8 | Stored byte at the readback index |
| pend_clr_i | input | 1 | Write-one-to-clear of the pending flag |
| armed_o | output | 1 | Any field enabled |
| pending_o | output | 1 | Sticky alarm status |
| irq_o | output | 1 | Single-cycle alarm event |

## Verification
On every cycle, the assertions check these properties:
- An interrupt only follows a tick taken while the alarm was armed.
- The pending flag rises together with the interrupt.
- The flag holds or clears according to the clear strobe.
- A lone disarm leaves nothing enabled.

Some behaviours show only in the bench's scenarios, compared against its reference model:
- Don't-care handling of disabled fields.
- Suppression by a single mismatching field.
- Retention of values across a disarm.
- Precedence of a same-cycle write over a disarm.
- Ignoring a write to the unused index.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;
  localparam int unsigned ALM_FIELDS = 7;
  localparam int unsigned ALM_BYTE_W = 8;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_WDAY  = 3'd3,
    FLD_DATE  = 3'd4,
    FLD_MONTH = 3'd5,
    FLD_YEAR  = 3'd6
  } alm_field_e;
endpackage

// File: rtl/rtc_alm_bank.sv
module rtc_alm_bank #(
  parameter int unsigned NUM_FIELDS = 7,
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned IDX_W      = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_i,
  input  logic [IDX_W-1:0]             wr_idx_i,
  input  logic [BYTE_W-1:0]            wr_data_i,
  input  logic                         disarm_i,
  input  logic [IDX_W-1:0]             rd_idx_i,
  output logic [BYTE_W-1:0]            rd_data_o,
  output logic [NUM_FIELDS*BYTE_W-1:0] bytes_o
);
  localparam int unsigned EN_BIT = BYTE_W - 1;

  logic [NUM_FIELDS*BYTE_W-1:0] bytes_q;

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
    logic [BYTE_W-1:0] q;
    logic [BYTE_W-1:0] d;
    logic              sel;
    logic              ld;

    assign sel = wr_i && (wr_idx_i == IDX_W'(k));
    assign ld  = sel || disarm_i;

    always_comb begin
      d = q;
      if (disarm_i) d[EN_BIT] = 1'b0;
      if (sel)      d = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= d;
    end

    assign bytes_q[k*BYTE_W +: BYTE_W] = q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NUM_FIELDS; k++) begin
      if (rd_idx_i == IDX_W'(k)) rd_data_o = bytes_q[k*BYTE_W +: BYTE_W];
    end
  end

  assign bytes_o = bytes_q;
endmodule

// File: rtl/rtc_alm_cmp.sv
module rtc_alm_cmp #(
  parameter int unsigned NUM_FIELDS = 7,
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned VAL_W      = 7
) (
  input  logic [NUM_FIELDS*BYTE_W-1:0] alm_i,
  input  logic [NUM_FIELDS*VAL_W-1:0]  time_i,
  output logic                         armed_o,
  output logic                         hit_o
);
  logic [NUM_FIELDS-1:0] en;
  logic [NUM_FIELDS-1:0] fld_ok;

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_cmp
    assign en[k]     = alm_i[k*BYTE_W + VAL_W];
    assign fld_ok[k] = !en[k] ||
                       (alm_i[k*BYTE_W +: VAL_W] == time_i[k*VAL_W +: VAL_W]);
  end

  assign armed_o = |en;
  assign hit_o   = armed_o && (&fld_ok);
endmodule

// File: rtl/rtc_alm_evt.sv
module rtc_alm_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic hit_i,
  input  logic clr_i,
  output logic irq_o,
  output logic pend_o
);
  logic irq_d, irq_q;
  logic pend_d, pend_q, pend_ld;

  always_comb begin
    irq_d   = tick_i && hit_i;
    pend_ld = irq_d || clr_i;
    pend_d  = irq_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_ld) pend_q <= pend_d;
  end

  assign irq_o  = irq_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alm_pkg::*;
#(
  parameter int unsigned NUM_FIELDS = ALM_FIELDS,
  parameter int unsigned BYTE_W     = ALM_BYTE_W,
  localparam int unsigned VAL_W     = BYTE_W - 1,
  localparam int unsigned IDX_W     = $clog2(NUM_FIELDS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick_i,
  input  logic [NUM_FIELDS*VAL_W-1:0] time_i,
  input  logic                        alm_wr_i,
  input  logic [IDX_W-1:0]            alm_wr_idx_i,
  input  logic [BYTE_W-1:0]           alm_wr_data_i,
  input  logic                        alm_disarm_i,
  input  logic [IDX_W-1:0]            alm_rd_idx_i,
  output logic [BYTE_W-1:0]           alm_rd_data_o,
  input  logic                        pend_clr_i,
  output logic                        armed_o,
  output logic                        pending_o,
  output logic                        irq_o
);
  logic [1:0]                   rst_sync_q;
  logic                         rst_sync_n;
  logic [NUM_FIELDS*BYTE_W-1:0] alm_bytes;
  logic                         hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  rtc_alm_bank #(
    .NUM_FIELDS(NUM_FIELDS), .BYTE_W(BYTE_W), .IDX_W(IDX_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_i     (alm_wr_i),
    .wr_idx_i (alm_wr_idx_i),
    .wr_data_i(alm_wr_data_i),
    .disarm_i (alm_disarm_i),
    .rd_idx_i (alm_rd_idx_i),
    .rd_data_o(alm_rd_data_o),
    .bytes_o  (alm_bytes)
  );

  rtc_alm_cmp #(
    .NUM_FIELDS(NUM_FIELDS), .BYTE_W(BYTE_W), .VAL_W(VAL_W)
  ) u_cmp (
    .alm_i  (alm_bytes),
    .time_i (time_i),
    .armed_o(armed_o),
    .hit_o  (hit)
  );

  rtc_alm_evt u_evt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick_i(tick_i),
    .hit_i (hit),
    .clr_i (pend_clr_i),
    .irq_o (irq_o),
    .pend_o(pending_o)
  );
endmodule

// File: rtl/rtc_alm_match_chk.sv
module rtc_alm_match_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_i,
  input logic alm_wr_i,
  input logic alm_disarm_i,
  input logic pend_clr_i,
  input logic armed_o,
  input logic pending_o,
  input logic irq_o
);
  p_irq_needs_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> !irq_o);

  p_irq_needs_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_o |=> !irq_o);

  p_irq_sets_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> pending_o);

  p_pending_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pending_o && !pend_clr_i |=> pending_o);

  p_pending_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pending_o && pend_clr_i && !tick_i |=> !pending_o);

  p_pending_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending_o) |-> irq_o);

  p_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    alm_disarm_i && !alm_wr_i |=> !armed_o);
endmodule

bind rtc_alarm_match rtc_alm_match_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .tick_i      (tick_i),
  .alm_wr_i    (alm_wr_i),
  .alm_disarm_i(alm_disarm_i),
  .pend_clr_i  (pend_clr_i),
  .armed_o     (armed_o),
  .pending_o   (pending_o),
  .irq_o       (irq_o)
);

// File: tb/rtc_alarm_match_bench.sv
module rtc_alarm_match_bench;
  logic        clk;
  logic        rst_n;
  logic        tick_i;
  logic [48:0] time_i;
  logic        alm_wr_i;
  logic [2:0]  alm_wr_idx_i;
  logic [7:0]  alm_wr_data_i;
  logic        alm_disarm_i;
  logic [2:0]  alm_rd_idx_i;
  logic [7:0]  alm_rd_data_o;
  logic        pend_clr_i;
  logic        armed_o, pending_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [7:0] m_alm [7];
  logic       m_pend, m_irq;

  rtc_alarm_match u_rtc_alarm_match (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .time_i(time_i),
    .alm_wr_i(alm_wr_i), .alm_wr_idx_i(alm_wr_idx_i), .alm_wr_data_i(alm_wr_data_i),
    .alm_disarm_i(alm_disarm_i), .alm_rd_idx_i(alm_rd_idx_i), .alm_rd_data_o(alm_rd_data_o),
    .pend_clr_i(pend_clr_i), .armed_o(armed_o), .pending_o(pending_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [48:0] pack_t(int s, int mi, int h, int wd, int d, int mo, int y);
    logic [48:0] t;
    t = '0;
    t[6:0] = 7'(s);   t[13:7] = 7'(mi); t[20:14] = 7'(h); t[27:21] = 7'(wd);
    t[34:28] = 7'(d); t[41:35] = 7'(mo); t[48:42] = 7'(y);
    return t;
  endfunction

  function automatic logic m_armed();
    logic a;
    a = 1'b0;
    for (int k = 0; k < 7; k++) a |= m_alm[k][7];
    return a;
  endfunction

  // Behavioural reference model, one update per clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 7; k++) m_alm[k] = 8'h00;
      m_pend = 1'b0;
      m_irq  = 1'b0;
    end else begin
      logic hit;
      hit = m_armed();
      for (int k = 0; k < 7; k++)
        if (m_alm[k][7] && (m_alm[k][6:0] != time_i[7*k +: 7])) hit = 1'b0;
      m_irq = tick_i && hit;
      if (m_irq) m_pend = 1'b1;
      else if (pend_clr_i) m_pend = 1'b0;
      if (alm_disarm_i) for (int k = 0; k < 7; k++) m_alm[k][7] = 1'b0;
      if (alm_wr_i && alm_wr_idx_i < 3'd7) m_alm[alm_wr_idx_i] = alm_wr_data_i;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk("R4 irq vs model", int'(irq_o), int'(m_irq));
    chk("R8 pending vs model", int'(pending_o), int'(m_pend));
    chk("R3 armed vs model", int'(armed_o), int'(m_armed()));
    chk("R2 readback vs model", int'(alm_rd_data_o),
        (alm_rd_idx_i < 3'd7) ? int'(m_alm[alm_rd_idx_i]) : 0);
    tick_i = 1'b0; alm_wr_i = 1'b0; alm_disarm_i = 1'b0; pend_clr_i = 1'b0;
    alm_rd_idx_i = (alm_rd_idx_i == 3'd7) ? 3'd0 : alm_rd_idx_i + 3'd1;
  endtask

  task automatic wr(int idx, logic [7:0] data);
    alm_wr_i = 1'b1; alm_wr_idx_i = 3'(idx); alm_wr_data_i = data;
    step();
  endtask

  task automatic tick_at(logic [48:0] t);
    time_i = t; tick_i = 1'b1;
    step();
  endtask

  task automatic rd_chk(string tag, int idx, int exp);
    alm_rd_idx_i = 3'(idx);
    #0.5;
    chk(tag, int'(alm_rd_data_o), exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [48:0] t0;
    rst_n = 1'b0; tick_i = 1'b0; time_i = '0; alm_wr_i = 1'b0; alm_wr_idx_i = '0;
    alm_wr_data_i = '0; alm_disarm_i = 1'b0; alm_rd_idx_i = '0; pend_clr_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();
    // R1 reset state
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 pending", int'(pending_o), 0);
    chk("R1 armed", int'(armed_o), 0);
    for (int i = 0; i < 8; i++) rd_chk("R1 byte", i, 0);

    t0 = pack_t(30, 15, 8, 3, 12, 6, 25);
    wr(0, 8'h9E); wr(1, 8'h8F); wr(2, 8'h88); wr(3, 8'h05);
    wr(4, 8'h8C); wr(5, 8'h86); wr(6, 8'h99);
    rd_chk("R2 seconds byte", 0, 'h9E);
    rd_chk("R2 weekday byte", 3, 'h05);
    chk("R3 armed after writes", int'(armed_o), 1);

    // R4 match with weekday disabled and mismatching
    tick_at(t0);
    chk("R4 irq on match", int'(irq_o), 1);
    chk("R8 pending with irq", int'(pending_o), 1);
    step();
    chk("R4 irq single cycle", int'(irq_o), 0);
    chk("R8 pending held", int'(pending_o), 1);

    // R7 one enabled field off
    tick_at(pack_t(30, 16, 8, 3, 12, 6, 25));
    chk("R7 minute mismatch", int'(irq_o), 0);
    chk("R8 pending still held", int'(pending_o), 1);
    pend_clr_i = 1'b1; step();
    chk("R8 cleared", int'(pending_o), 0);

    // R6 time matches, no tick
    time_i = t0;
    repeat (3) step();
    chk("R6 no tick no irq", int'(irq_o), 0);

    // R8 clear and match together
    pend_clr_i = 1'b1; tick_at(t0);
    chk("R8 set wins over clear", int'(pending_o), 1);
    pend_clr_i = 1'b1; step();

    // R10 unused index
    wr(7, 8'hFF);
    rd_chk("R10 index 7 reads 0", 7, 0);
    rd_chk("R10 seconds kept", 0, 'h9E);
    rd_chk("R10 year kept", 6, 'h99);

    // R9 disarm keeps values, R5 no enables
    alm_disarm_i = 1'b1; step();
    chk("R9 armed cleared", int'(armed_o), 0);
    rd_chk("R9 seconds value kept", 0, 'h1E);
    rd_chk("R9 date value kept", 4, 'h0C);
    tick_at(t0);
    chk("R5 unarmed no irq", int'(irq_o), 0);

    // R9 disarm with same-cycle write; only year enabled
    alm_disarm_i = 1'b1; wr(6, 8'h99);
    chk("R9 write wins", int'(armed_o), 1);
    rd_chk("R9 year written", 6, 'h99);
    tick_at(pack_t(1, 2, 3, 4, 5, 6, 25));
    chk("R4 year-only match", int'(irq_o), 1);
    tick_at(pack_t(1, 2, 3, 4, 5, 6, 26));
    chk("R7 year mismatch", int'(irq_o), 0);
    repeat (2) step();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule